// File: doc/BRIEF.md
# Indirect Configuration Access Port

This block gives a host two I/O windows into the configuration space of a single target function. The first window, at port offsets 0 to 3, holds a 32-bit selector register. It has an enable bit, a bus number, a device/function number and a dword register index. The second window, at port offsets 4 to 7, is the data window. A byte, halfword or word access there reaches the configuration byte that the selector names, plus the low two bits of the port offset.

The function's 256-byte space is held in a local byte array. A fixed set of identity bytes is read-only and returns values set by parameters. When a selector is disabled, misaligned or points at nothing, a read returns all-ones sized to the access width. Every forwarded write that touches the command register raises a one-cycle pulse, so that neighbouring logic can recompute its address windows.

Accesses arrive as single-cycle strobes. Read data comes back, with a valid flag, on the cycle after the strobe.

Top module: `cfg_port_decoder`

## Requirements
- R1: The selector register resets to 0. A word write (size code 2 or 3) at port offset 0 stores all 32 bits, and a word read at port offset 0 returns the stored value.
- R2: Any other access to port offsets 0 to 3 (a narrower size, or offset 1, 2 or 3) leaves the selector unchanged. A read of that kind returns the all-ones value for its size.
- R3: A data-window access is forwarded only when selector bit 31 is 1 and selector bits 1:0 are both 0. Otherwise a write changes no configuration byte and a read misses.
- R4: The function answers only when selector bits 23:16 equal 0 and bits 15:8 equal the parameter DEVFN. Any other value misses in the same way as R3.
- R5: The first byte reached is {selector[7:2], port[1:0]}. Data is little-endian: lane k of the data bus maps to that byte plus k. Byte addresses wrap modulo 256.
- R6: Size code 0 moves 1 byte, code 1 moves 2 bytes, and codes 2 and 3 move 4 bytes. A missed read returns 0xFF, 0xFFFF or 0xFFFFFFFF for these sizes. A hit read returns zero above the lanes it covers.
- R7: Bytes 0x00–0x03, 0x08–0x0B, 0x0E and 0x3D cannot be written. They read as VENDOR_ID (0x00–0x01), DEVICE_ID (0x02–0x03), REVISION_ID (0x08), CLASS_CODE (0x09–0x0B), HEADER_TYPE (0x0E) and IRQ_PIN (0x3D). The other bytes of the same write are still stored. All writable bytes reset to 0.
- R8: `cmd_update` is high for exactly the one cycle after a forwarded write whose byte range overlaps 0x04–0x05, and is low after every other strobe.
- R9: `rd_valid` is high for exactly the one cycle after each read strobe, with `rd_data` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Single-cycle access strobe |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_port | input | 3 | Port offset from the base (0–3 selector, 4–7 data window) |
| acc_size | input | 2 | Access size code (0 byte, 1 halfword, 2/3 word) |
| acc_wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| cmd_update | output | 1 | Pulse after a write that overlaps the command register |

## Verification
The embedded assertions run on every cycle and cover the following:
- the selector holds unless it is written;
- the command pulse and the read-valid flag each follow a strobe of the right kind;
- a byte read returns zeros above its lane;
- configuration storage stays still when no forwarded write occurs.

Only the bench scenarios can show the rest:
- the protection map;
- the little-endian lane order and the wrap at the top of the space;
- the exact all-ones patterns on each kind of miss;
- the overlap decision for every start byte and width near the command register.

// File: rtl/cfgp_pkg.sv
// Package: shared size encoding and helpers for the configuration access port.
// Assumes size codes 2 and 3 both mean a 4-byte access.
package cfgp_pkg;
    localparam int SEL_W  = 32;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORDX = 2'd3
    } acc_size_e;

    // Number of bytes moved by a size code.
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // All-ones pattern sized to the access width.
    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/cfgp_sel_reg.sv
// Module: holds the 32-bit selector register and splits it into fields.
// Assumes the parent qualifies wr_en (word write at port offset 0 only).
module cfgp_sel_reg
    import cfgp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wdata,
    output logic [SEL_W-1:0] sel_q,
    output logic             sel_enable,
    output logic [7:0]       sel_bus,
    output logic [7:0]       sel_devfn,
    output logic [5:0]       sel_dword,
    output logic [1:0]       sel_low
);
    // Purpose: latch the selector on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wr_en)
            sel_q <= wdata;
    end

    // Purpose: field decode of the selector.
    always_comb begin
        sel_enable = sel_q[31];
        sel_bus    = sel_q[23:16];
        sel_devfn  = sel_q[15:8];
        sel_dword  = sel_q[7:2];
        sel_low    = sel_q[1:0];
    end

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sel_q)); // R2
endmodule

// File: rtl/cfgp_space.sv
// Module: 256-byte configuration space of one function, with fixed read-only
// identity bytes. Reads are combinational over four lanes starting at
// base_addr (wrapping modulo 256). A write stores up to nbytes lanes and
// skips protected bytes. Assumes nbytes is 1, 2 or 4.
module cfgp_space
    import cfgp_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'hABCD,
    parameter logic [15:0] DEVICE_ID   = 16'h0042,
    parameter logic [7:0]  REVISION_ID = 8'h03,
    parameter logic [23:0] CLASS_CODE  = 24'h060400,
    parameter logic [7:0]  HEADER_TYPE = 8'h00,
    parameter logic [7:0]  IRQ_PIN     = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        base_addr,
    input  logic [2:0]        nbytes,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 256;

    logic [7:0] mem [DEPTH];
    logic [7:0] lane_addr [LANES];

    // Protected byte offsets.
    function automatic logic is_ro(input logic [7:0] a);
        case (a)
            8'h00, 8'h01, 8'h02, 8'h03,
            8'h08, 8'h09, 8'h0A, 8'h0B,
            8'h0E, 8'h3D: return 1'b1;
            default:      return 1'b0;
        endcase
    endfunction

    // Identity values returned for protected bytes.
    function automatic logic [7:0] id_byte(input logic [7:0] a);
        case (a)
            8'h00:   return VENDOR_ID[7:0];
            8'h01:   return VENDOR_ID[15:8];
            8'h02:   return DEVICE_ID[7:0];
            8'h03:   return DEVICE_ID[15:8];
            8'h08:   return REVISION_ID;
            8'h09:   return CLASS_CODE[7:0];
            8'h0A:   return CLASS_CODE[15:8];
            8'h0B:   return CLASS_CODE[23:16];
            8'h0E:   return HEADER_TYPE;
            8'h3D:   return IRQ_PIN;
            default: return 8'h00;
        endcase
    endfunction

    // Purpose: per-lane byte address with modulo-256 wrap.
    always_comb begin
        for (int i = 0; i < LANES; i++)
            lane_addr[i] = base_addr + 8'(i);
    end

    // Purpose: store writable lanes of a forwarded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++)
                mem[k] <= 8'h00;
        end else if (wr_en) begin
            for (int i = 0; i < LANES; i++)
                if (3'(i) < nbytes && !is_ro(lane_addr[i]))
                    mem[lane_addr[i]] <= wdata[8*i +: 8];
        end
    end

    // Purpose: assemble four read lanes, with identity bytes substituted.
    always_comb begin
        for (int i = 0; i < LANES; i++)
            rdata[8*i +: 8] = is_ro(lane_addr[i]) ? id_byte(lane_addr[i])
                                                  : mem[lane_addr[i]];
    end

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem[4]) && $stable(mem[255])); // R3
endmodule

// File: rtl/cfg_port_decoder.sv
// Module: top of the indirect configuration access port. Port offsets 0-3
// hold the selector; offsets 4-7 are the data window. Decodes hits,
// returns sized all-ones on a miss and pulses cmd_update on command
// register writes. Assumes one strobe per cycle at most.
module cfg_port_decoder
    import cfgp_pkg::*;
#(
    parameter logic [7:0]  DEVFN       = 8'h18,
    parameter logic [15:0] VENDOR_ID   = 16'hABCD,
    parameter logic [15:0] DEVICE_ID   = 16'h0042,
    parameter logic [7:0]  REVISION_ID = 8'h03,
    parameter logic [23:0] CLASS_CODE  = 24'h060400,
    parameter logic [7:0]  HEADER_TYPE = 8'h00,
    parameter logic [7:0]  IRQ_PIN     = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [2:0]        acc_port,
    input  logic [1:0]        acc_size,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              cmd_update
);
    localparam logic [8:0] CMD_LO = 9'h004;
    localparam logic [8:0] CMD_HI = 9'h005;

    logic [SEL_W-1:0]  sel_q;
    logic              sel_enable;
    logic [7:0]        sel_bus;
    logic [7:0]        sel_devfn;
    logic [5:0]        sel_dword;
    logic [1:0]        sel_low;
    logic              is_sel_port;
    logic              sel_word_acc;
    logic              sel_wr;
    logic              target_hit;
    logic              data_wr;
    logic [7:0]        byte_addr;
    logic [2:0]        nbytes;
    logic [DATA_W-1:0] width_mask;
    logic [DATA_W-1:0] space_rdata;
    logic              cmd_overlap;
    logic [1:0]        size_q;

    // Purpose: classify the strobe and decide whether it reaches the function.
    always_comb begin
        is_sel_port  = !acc_port[2];
        sel_word_acc = is_sel_port && (acc_port[1:0] == 2'd0) && acc_size[1];
        sel_wr       = acc_valid && acc_write && sel_word_acc;
        target_hit   = sel_enable && (sel_low == 2'd0) &&
                       (sel_bus == 8'd0) && (sel_devfn == DEVFN);
        data_wr      = acc_valid && acc_write && !is_sel_port && target_hit;
        byte_addr    = {sel_dword, acc_port[1:0]};
        nbytes       = size_bytes(acc_size);
        width_mask   = size_mask(acc_size);
        cmd_overlap  = ({1'b0, byte_addr} <= CMD_HI) &&
                       (({1'b0, byte_addr} + {6'd0, nbytes}) > CMD_LO);
    end

    cfgp_sel_reg u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (sel_wr),
        .wdata      (acc_wdata),
        .sel_q      (sel_q),
        .sel_enable (sel_enable),
        .sel_bus    (sel_bus),
        .sel_devfn  (sel_devfn),
        .sel_dword  (sel_dword),
        .sel_low    (sel_low)
    );

    cfgp_space #(
        .VENDOR_ID   (VENDOR_ID),
        .DEVICE_ID   (DEVICE_ID),
        .REVISION_ID (REVISION_ID),
        .CLASS_CODE  (CLASS_CODE),
        .HEADER_TYPE (HEADER_TYPE),
        .IRQ_PIN     (IRQ_PIN)
    ) u_space (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (data_wr),
        .base_addr (byte_addr),
        .nbytes    (nbytes),
        .wdata     (acc_wdata),
        .rdata     (space_rdata)
    );

    // Purpose: register read response, its valid flag and the command pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            cmd_update <= 1'b0;
            size_q     <= 2'd0;
        end else begin
            rd_valid   <= acc_valid && !acc_write;
            cmd_update <= data_wr && cmd_overlap;
            size_q     <= acc_size;
            if (acc_valid && !acc_write) begin
                if (sel_word_acc)
                    rd_data <= sel_q;
                else if (!is_sel_port && target_hit)
                    rd_data <= space_rdata & width_mask;
                else
                    rd_data <= width_mask;
            end
        end
    end

    AST_CMD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_update |-> $past(acc_valid && acc_write && acc_port[2])); // R8
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_valid && !acc_write)); // R9
    AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && size_q == 2'd0) |-> (rd_data[31:8] == 24'd0)); // R6
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_update && !$past(acc_valid)) |-> 1'b0); // R8
endmodule

// File: tb/cfg_port_decoder_tb.sv
module cfg_port_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] DEVFN = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [2:0]  acc_port = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        cmd_update;

    int checks = 0;
    int errors = 0;

    logic [7:0]  m_mem [256];
    logic [31:0] m_sel;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_port_decoder #(.DEVFN(DEVFN)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_port(acc_port), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .cmd_update(cmd_update)
    );

    function automatic logic ro(input logic [7:0] a);
        return (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0B) || a == 8'h0E || a == 8'h3D;
    endfunction

    function automatic int nb(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] ones(input logic [1:0] s);
        return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic hit();
        return m_sel[31] && m_sel[1:0] == 2'd0 && m_sel[23:16] == 8'd0 && m_sel[15:8] == DEVFN;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One strobe; checks the registered outputs one cycle later against the model.
    task automatic access(input string req, input logic wr, input logic [2:0] port,
                          input logic [1:0] sz, input logic [31:0] wd);
        logic [31:0] exp_rd;
        logic        exp_pulse;
        int          base;
        exp_rd = ones(sz);
        exp_pulse = 1'b0;
        base = {m_sel[7:2], port[1:0]};
        if (!port[2]) begin
            if (port[1:0] == 2'd0 && sz[1]) begin
                if (wr) m_sel = wd; else exp_rd = m_sel;
            end
        end else if (hit()) begin
            if (wr) begin
                for (int i = 0; i < nb(sz); i++)
                    if (!ro(8'(base + i))) m_mem[8'(base + i)] = wd[8*i +: 8];
                exp_pulse = (base <= 5) && (base + nb(sz) > 4);
            end else begin
                exp_rd = 0;
                for (int i = 0; i < nb(sz); i++)
                    exp_rd[8*i +: 8] = m_mem[8'(base + i)];
            end
        end
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_port = port; acc_size = sz; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        if (wr) check({req, " R8 pulse"}, {31'd0, cmd_update}, {31'd0, exp_pulse});
        else begin
            check({req, " R9 valid"}, {31'd0, rd_valid}, 32'd1);
            check(req, rd_data, exp_rd);
        end
    endtask

    task automatic set_sel(input logic [31:0] v);
        access("R1 sel write", 1'b1, 3'd0, 2'd2, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) m_mem[a] = 8'h00;
        m_mem[0] = 8'hCD; m_mem[1] = 8'hAB; m_mem[2] = 8'h42; m_mem[3] = 8'h00;
        m_mem[8] = 8'h03; m_mem[9] = 8'h00; m_mem[10] = 8'h04; m_mem[11] = 8'h06;
        m_mem[14] = 8'h00; m_mem[8'h3D] = 8'h01;
        m_sel = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        check("R9 rd_valid reset", {31'd0, rd_valid}, 32'd0);
        check("R8 cmd_update reset", {31'd0, cmd_update}, 32'd0);
        access("R1 sel reset read", 1'b0, 3'd0, 2'd2, 0);
        access("R3 disabled read", 1'b0, 3'd4, 2'd0, 0);
        // Selector register and narrow selector accesses
        set_sel(32'h1234_5678);
        access("R1 sel readback", 1'b0, 3'd0, 2'd2, 0);
        access("R2 narrow sel write", 1'b1, 3'd1, 2'd0, 32'hFF);
        access("R2 half sel write", 1'b1, 3'd0, 2'd1, 32'hFFFF);
        access("R2 word sel off2", 1'b1, 3'd2, 2'd3, 32'hFFFF_FFFF);
        access("R1 sel unchanged", 1'b0, 3'd0, 2'd3, 0);
        access("R2 narrow sel read", 1'b0, 3'd0, 2'd0, 0);
        access("R2 half sel read", 1'b1 ^ 1'b1, 3'd3, 2'd1, 0);
        // Writes while disabled are dropped (R3)
        set_sel({1'b0, 7'd0, 8'd0, DEVFN, 8'h40});
        access("R3 disabled write", 1'b1, 3'd4, 2'd2, 32'hDEAD_BEEF);
        // Full sweep: word writes to every dword, byte/half/word readback
        for (int d = 0; d < 64; d++) begin
            set_sel({1'b1, 7'd0, 8'd0, DEVFN, 6'(d), 2'b00});
            access("R7 sweep write", 1'b1, 3'd4, 2'd2, {8'(d) ^ 8'hA5, 8'(d), 8'(3*d), 8'(d) ^ 8'h5A});
        end
        for (int d = 0; d < 64; d++) begin
            set_sel({1'b1, 7'd0, 8'd0, DEVFN, 6'(d), 2'b00});
            for (int p = 0; p < 4; p++)
                access("R5 byte read", 1'b0, 3'(4 + p), 2'd0, 0);
            access("R6 half read", 1'b0, 3'd5, 2'd1, 0);
            access("R7 word read", 1'b0, 3'd4, 2'd2, 0);
        end
        // Partially protected write
        set_sel({1'b1, 7'd0, 8'd0, DEVFN, 6'h03, 2'b00});
        access("R7 mixed write", 1'b1, 3'd6, 2'd1, 32'h0000_7755);
        access("R7 mixed read", 1'b0, 3'd4, 2'd2, 0);
        // Wrap at the top of the space
        set_sel({1'b1, 7'd0, 8'd0, DEVFN, 6'h3F, 2'b00});
        access("R5 wrap write", 1'b1, 3'd6, 2'd2, 32'h4433_2211);
        access("R5 wrap read", 1'b0, 3'd6, 2'd2, 0);
        access("R5 wrap tail", 1'b0, 3'd4, 2'd2, 0);
        // Command overlap for every start byte and width in dwords 0-1
        for (int d = 0; d < 2; d++) begin
            set_sel({1'b1, 7'd0, 8'd0, DEVFN, 6'(d), 2'b00});
            for (int p = 0; p < 4; p++)
                for (int s = 0; s < 3; s++)
                    access("R8 overlap", 1'b1, 3'(4 + p), 2'(s), 32'hC3C3_C3C3);
        end
        // Misses: each cause at each width, writes dropped
        for (int s = 0; s < 3; s++) begin
            set_sel({1'b1, 7'd0, 8'd1, DEVFN, 8'h04});
            access("R4 bus miss", 1'b0, 3'd4, 2'(s), 0);
            access("R4 bus miss write", 1'b1, 3'd4, 2'(s), 32'h1111_1111);
            set_sel({1'b1, 7'd0, 8'd0, DEVFN + 8'd1, 8'h04});
            access("R4 devfn miss", 1'b0, 3'd4, 2'(s), 0);
            access("R4 devfn miss write", 1'b1, 3'd4, 2'(s), 32'h2222_2222);
            set_sel({1'b1, 7'd0, 8'd0, DEVFN, 8'h05});
            access("R3 misaligned miss", 1'b0, 3'd4, 2'(s), 0);
            access("R3 misaligned write", 1'b1, 3'd4, 2'(s), 32'h3333_3333);
            set_sel({1'b0, 7'd0, 8'd0, DEVFN, 8'h04});
            access("R6 disabled miss", 1'b0, 3'd4, 2'(s), 0);
        end
        set_sel({1'b1, 7'd0, 8'd0, DEVFN, 8'h04});
        access("R3 dropped writes readback", 1'b0, 3'd4, 2'd2, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule